// File: doc/BRIEF.md
# SPI Master Shift Engine with Sticky Status Flags

The block moves 8-bit characters out over a four-wire serial link in master mode and stores what comes back in a one-character receive buffer. Software reaches it through a small register port. A select bit chooses between a 16-bit control/status word and the data buffer. Writing the data buffer while the engine is idle, enabled and in master mode starts a transfer. During the transfer the slave-select output is held low, and eight bits are shifted most significant bit first. The serial clock is derived from the system clock by a fixed divider parameter.

Four sticky flags report the outcome of the link:

- a completion flag at the end of each character;
- a receive-overrun flag when a character arrives while the previous one is still unread (the newer character is the one thrown away);
- a write-collision flag for every attempt to write the buffer during a transfer;
- a mode-fault flag when an external device pulls the slave-select sense input low while fault detection is armed.

A mode fault also drops master mode and aborts any transfer in progress. Only hardware can set a flag, and only software writing 0 to it can clear it. The completion, overrun and collision flags are ORed into one interrupt, which is gated by an enable input.

The serial mode is fixed:

- the clock idles low;
- the output data bit is stable before each rising clock edge;
- the input line is sampled on the rising edge;
- the output moves on to the next bit on the falling edge.

Top module: `spi_ctl_flags`

## Requirements
- R1: All control bits reset to 0. Bits 15..8 of both register words always read 0, and writing them has no effect.
- R2: The control word layout is fixed:
  - bit 7 = busy (read-only; writes ignored);
  - bit 6 = complete;
  - bit 5 = overrun;
  - bit 4 = collision;
  - bit 3 = mode fault;
  - bit 2 = fault-detect enable, bit 1 = master mode, bit 0 = module enable.
  Bits 2..0 read back the last value written. Select 0 addresses the control word and select 1 the data buffer, whose low 8 bits hold the receive buffer.
- R3: A data write (select 1) starts a transfer only when busy is 0 and enable and master are both 1. From the next cycle, busy reads 1 and slave-select is low for exactly 16*HALF_DIV cycles. Any other data write starts nothing.
- R4: A transfer produces exactly 8 rising clock edges, each half period lasting HALF_DIV system cycles. The clock idles low. The output line carries the written byte MSB first, stable at each rising edge.
- R5: At the end of each transfer the complete flag is set and busy clears on the same edge. If the buffer was empty or is being read in that cycle, the 8 sampled input bits become the data-buffer value.
- R6: If a character finishes while the buffer holds an unread character and no read happens in that cycle, the new character is dropped, the old one is kept and the overrun flag is set.
- R7: A data write while busy is 1 leaves the running transfer and its byte unchanged and sets the collision flag.
- R8: Writing 1 to a flag bit (6..3) has no effect, and writing 0 clears it. A hardware set in the same cycle as a software clear wins.
- R9: A read of the data buffer (select 1 with read strobe) marks the buffer empty. That empty state is the one the next completed character is checked against.
- R10: The interrupt output equals the enable input ANDed with the OR of complete, overrun and collision. The mode-fault flag does not drive it.
- R11: When fault-detect enable and master mode are 1 and the slave-select sense input is low at a clock edge, the following happen on that edge:
  - mode fault is set and master mode clears;
  - any transfer stops without setting the complete flag;
  - busy reads 0, slave-select goes high and the serial clock goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | 0 selects control word, 1 selects data buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes the data buffer) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |
| ss_sense_n | input | 1 | External slave-select sense for fault detection |

## Verification
The bench aims at the edge on which a character finishes:

- A read strobe in exactly that cycle must store the new character without an overrun. A design that tests only the stale full bit would raise a false overrun.
- A software clear of the completion flag in that cycle must lose to the hardware set. A design with the priorities reversed would silently drop a completion.

Overrun is driven with a second character that differs from the unread one. A design that overwrote the buffer would show the newer byte. A buffer write in the middle of a character must leave the shifted bit pattern intact. Pulling the sense line low mid-transfer must leave busy, the completion flag and the interrupt all clear. A design that let the fault slip would keep clocking or would report a completion.

// File: rtl/spi_ctl_pkg.sv
// Package: shared bit positions of the control word and the register select.
// Assumes an 8-bit control field placed in the low byte of a wider register.
package spi_ctl_pkg;
    localparam int CTL_W      = 8;  // implemented control bits
    localparam int B_EN       = 0;  // module enable
    localparam int B_MSTR     = 1;  // master mode
    localparam int B_FLTEN    = 2;  // fault-detect enable
    localparam int FLAG_LO    = 3;  // lowest sticky flag bit
    localparam int NFLAG      = 4;  // sticky flags: fault, collision, overrun, complete
    localparam int F_FAULT    = 0;  // index into the flag vector
    localparam int F_COLL     = 1;
    localparam int F_OVR      = 2;
    localparam int F_DONE     = 3;
    localparam int B_BUSY     = 7;  // read-only busy bit

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/spi_tick_gen.sv
// Module: divides the system clock into half-period ticks for the serial clock.
// Assumes HALF_DIV >= 1; the counter rests at 0 whenever run is low.
module spi_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Count system cycles within one half period while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
// Module: master-mode shift engine for one character, MSB first.
// Clock idles low; output bit changes on falling edges, input sampled on rising.
// Assumes start is only raised while idle; abort has priority over everything.
module spi_shift_core #(
    parameter int CHAR_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CHAR_W-1:0] tx_byte,
    input  logic              miso,
    output logic              busy,
    output logic              ss_n,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [CHAR_W-1:0] rx_byte
);
    localparam int BW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(CHAR_W - 1);

    logic              tick;
    logic [CHAR_W-1:0] tx_sh_q;
    logic [CHAR_W-1:0] rx_sh_q;
    logic [BW-1:0]     bit_q;

    spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    assign done    = busy && tick && sclk && (bit_q == LAST_BIT) && !abort;
    assign mosi    = busy ? tx_sh_q[CHAR_W-1] : 1'b0;
    assign rx_byte = rx_sh_q;

    // Sequence one character: load, toggle clock on ticks, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            ss_n    <= 1'b1;
            sclk    <= 1'b0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
            ss_n  <= 1'b1;
            sclk  <= 1'b0;
            bit_q <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            ss_n    <= 1'b0;
            sclk    <= 1'b0;
            tx_sh_q <= tx_byte;
            bit_q   <= '0;
        end else if (busy && tick) begin
            sclk <= ~sclk;
            if (!sclk) begin
                rx_sh_q <= {rx_sh_q[CHAR_W-2:0], miso};
            end else if (bit_q == LAST_BIT) begin
                busy  <= 1'b0;
                ss_n  <= 1'b1;
                bit_q <= '0;
            end else begin
                tx_sh_q <= {tx_sh_q[CHAR_W-2:0], 1'b0};
                bit_q   <= bit_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_sticky_bit.sv
// Module: one status flag set by hardware and cleared only by a software 0.
// A hardware set in the same cycle as a software clear wins.
module spi_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q_o
);
    // Hold the flag until software writes 0 with no concurrent set.
    always_ff @(posedge clk) begin
        if (!rst_n)               q_o <= 1'b0;
        else if (set_i)           q_o <= 1'b1;
        else if (wr_i && !wbit_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/spi_ctl_regfile.sv
// Module: control/status word, receive buffer, start/collision/fault decode
// and interrupt merge. Assumes single-cycle read and write strobes.
module spi_ctl_regfile
    import spi_ctl_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              ss_sense_n,
    input  logic              irq_en,
    output logic              start,
    output logic              abort,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              irq
);
    logic              en_q, mstr_q, flten_q;
    logic              full_q;
    logic [CHAR_W-1:0] rxbuf_q;
    logic [NFLAG-1:0]  flag_set, flag_q;
    logic              ctrl_wr, data_wr, data_rd, fault, keep_old;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[REG_W-1:CTL_W];

    assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
    assign data_wr  = reg_wr && (reg_sel == SEL_DATA);
    assign data_rd  = reg_rd && (reg_sel == SEL_DATA);
    assign fault    = flten_q && mstr_q && !ss_sense_n;
    assign abort    = fault;
    assign start    = data_wr && !busy && en_q && mstr_q && !fault;
    assign tx_byte  = reg_wdata[CHAR_W-1:0];
    assign keep_old = full_q && !data_rd;

    assign flag_set[F_FAULT] = fault;
    assign flag_set[F_COLL]  = data_wr && busy;
    assign flag_set[F_OVR]   = done && keep_old;
    assign flag_set[F_DONE]  = done;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        spi_sticky_bit u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[i]),
            .wr_i  (ctrl_wr),
            .wbit_i(reg_wdata[FLAG_LO+i]),
            .q_o   (flag_q[i])
        );
    end

    // Plain mode bits; a mode fault forces master mode off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mstr_q  <= 1'b0;
            flten_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q    <= reg_wdata[B_EN];
                mstr_q  <= reg_wdata[B_MSTR];
                flten_q <= reg_wdata[B_FLTEN];
            end
            if (fault) mstr_q <= 1'b0;
        end
    end

    // Receive buffer: accept a finished character unless an unread one stays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            rxbuf_q <= '0;
        end else if (done && !keep_old) begin
            full_q  <= 1'b1;
            rxbuf_q <= rx_byte;
        end else if (data_rd) begin
            full_q  <= 1'b0;
        end
    end

    // Read mux for the selected register.
    always_comb begin
        if (reg_sel == SEL_DATA)
            reg_rdata = {{(REG_W-CHAR_W){1'b0}}, rxbuf_q};
        else
            reg_rdata = {{(REG_W-CTL_W){1'b0}}, busy, flag_q[F_DONE], flag_q[F_OVR],
                         flag_q[F_COLL], flag_q[F_FAULT], flten_q, mstr_q, en_q};
    end

    assign irq = irq_en && (flag_q[F_DONE] || flag_q[F_OVR] || flag_q[F_COLL]);
endmodule

// File: rtl/spi_ctl_flags.sv
// Module: top of the SPI master with sticky status flags.
// Joins the register file and the shift engine; all logic is synchronous to clk.
// Assumes ss_sense_n is already synchronous to clk.
module spi_ctl_flags #(
    parameter int REG_W    = 16,
    parameter int CHAR_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_en,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             ss_n,
    input  logic             ss_sense_n
);
    logic              eng_busy, eng_done, eng_start, eng_abort;
    logic [CHAR_W-1:0] eng_tx, eng_rx;

    spi_ctl_regfile #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_byte   (eng_rx),
        .ss_sense_n(ss_sense_n),
        .irq_en    (irq_en),
        .start     (eng_start),
        .abort     (eng_abort),
        .tx_byte   (eng_tx),
        .irq       (irq)
    );

    spi_shift_core #(.CHAR_W(CHAR_W), .HALF_DIV(HALF_DIV)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .abort  (eng_abort),
        .tx_byte(eng_tx),
        .miso   (miso),
        .busy   (eng_busy),
        .ss_n   (ss_n),
        .sclk   (sclk),
        .mosi   (mosi),
        .done   (eng_done),
        .rx_byte(eng_rx)
    );
endmodule

// File: rtl/spi_ctl_flags_chk.sv
// Checker: temporal properties of the SPI top, attached through bind.
module spi_ctl_flags_chk #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic             ss_n,
    input logic             sclk,
    input logic             irq,
    input logic             irq_en,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [REG_W-1:0] reg_rdata
);
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:8] == '0);

    a_r3_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_sel));

    a_r3_select_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy != ss_n);

    a_r4_clock_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r11_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!busy && ss_n && !sclk));
endmodule

bind spi_ctl_flags spi_ctl_flags_chk #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .done     (eng_done),
    .fault    (eng_abort),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .irq      (irq),
    .irq_en   (irq_en),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_rdata(reg_rdata)
);

// File: tb/spi_ctl_flags_bench.sv
// Bench: behavioural cycle model compared every clock, plus directed checks.
module spi_ctl_flags_bench;
    localparam int HALF = 2;
    localparam int XFER = 16 * HALF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_sel = 0, reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        irq_en = 0, irq, sclk, mosi, miso, ss_n;
    logic        ss_sense_n = 1;
    logic        inv = 0;
    int          checks = 0, fails = 0;
    bit          finished = 0;

    always #10 clk = ~clk;
    assign miso = mosi ^ inv;

    spi_ctl_flags #(.HALF_DIV(HALF)) u_spi_ctl_flags (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .ss_sense_n(ss_sense_n)
    );

    // Reference model state
    bit m_busy, m_cmpl, m_ovr, m_wcol, m_modf, m_fe, m_ms, m_en, m_full;
    bit [7:0] m_rx, m_byte;
    int m_t;

    always @(posedge clk) begin
        bit o_busy, o_en, o_ms, o_fe, flt, drd, dwr, cwr, dn;
        if (!rst_n) begin
            {m_busy, m_cmpl, m_ovr, m_wcol, m_modf, m_fe, m_ms, m_en, m_full} = '0;
            m_rx = 0; m_byte = 0; m_t = 0;
        end else begin
            o_busy = m_busy; o_en = m_en; o_ms = m_ms; o_fe = m_fe;
            flt = o_fe && o_ms && !ss_sense_n;
            drd = reg_rd && reg_sel; dwr = reg_wr && reg_sel; cwr = reg_wr && !reg_sel;
            dn = 0;
            if (flt) m_busy = 0;
            else if (o_busy) begin
                if (m_t == XFER - 1) begin dn = 1; m_busy = 0; end
                else m_t++;
            end
            if (cwr) begin
                m_en = reg_wdata[0]; m_ms = reg_wdata[1]; m_fe = reg_wdata[2];
                if (!reg_wdata[3]) m_modf = 0;
                if (!reg_wdata[4]) m_wcol = 0;
                if (!reg_wdata[5]) m_ovr = 0;
                if (!reg_wdata[6]) m_cmpl = 0;
            end
            if (flt) begin m_modf = 1; m_ms = 0; end
            if (dn) begin
                m_cmpl = 1;
                if (m_full && !drd) m_ovr = 1;
                else begin m_rx = m_byte; m_full = 1; end
            end else if (drd) m_full = 0;
            if (dwr && o_busy) m_wcol = 1;
            if (dwr && !o_busy && o_en && o_ms && !flt) begin
                m_busy = 1; m_t = 0; m_byte = reg_wdata[7:0] ^ {8{inv}};
            end
        end
    end

    function automatic [15:0] exp_word(input bit sel);
        if (sel) return {8'h00, m_rx};
        return {8'h00, m_busy, m_cmpl, m_ovr, m_wcol, m_modf, m_fe, m_ms, m_en};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R2 word, R3 select, R10 interrupt)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 register word", reg_rdata, exp_word(reg_sel));
            chk("R3 slave select", {15'd0, ss_n}, {15'd0, !m_busy});
            chk("R10 interrupt", {15'd0, irq}, {15'd0, irq_en && (m_cmpl || m_ovr || m_wcol)});
        end
    end

    // Capture of the serial output on rising clock edges (R4)
    logic [7:0] cap = 0;
    int rises = 0;
    always @(posedge sclk) begin
        cap <= {cap[6:0], mosi};
        rises <= rises + 1;
    end

    task automatic cyc(); @(posedge clk); #2; endtask
    task automatic wcyc(input int n); for (int i = 0; i < n; i++) cyc(); endtask
    task automatic wr(input bit sel, input logic [15:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d; cyc(); reg_wr = 0; reg_sel = 0;
    endtask
    task automatic rd_data(); reg_sel = 1; reg_rd = 1; cyc(); reg_rd = 0; reg_sel = 0; endtask
    task automatic peek(input bit sel, input string tag, input logic [15:0] exp);
        reg_sel = sel; @(negedge clk); chk(tag, reg_rdata, exp); #2 reg_sel = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wcyc(3); rst_n = 1; cyc();
        peek(0, "R1 reset control word", 16'h0000);
        chk("R3 reset select high", {15'd0, ss_n}, 16'd1);
        chk("R4 reset clock low", {15'd0, sclk}, 16'd0);

        // R3: data write while disabled starts nothing
        wr(1, 16'h00A5); wcyc(4);
        peek(0, "R3 no start when disabled", 16'h0000);
        chk("R3 select stays high", {15'd0, ss_n}, 16'd1);

        // R1/R2/R8: ones to reserved, busy and flag bits are ignored
        wr(0, 16'hFFFB);
        peek(0, "R1 R8 reserved and flag ones ignored", 16'h0003);

        // R4/R5/R10: first transfer, loop back unchanged
        rises = 0; irq_en = 1;
        wr(1, 16'h00A5); cyc();
        peek(0, "R3 busy during transfer", 16'h0083);
        wcyc(XFER);
        chk("R4 eight rising edges", 16'(rises), 16'd8);
        chk("R4 output bits MSB first", {8'h00, cap}, 16'h00A5);
        peek(0, "R5 complete flag set", 16'h0043);
        chk("R10 irq from complete", {15'd0, irq}, 16'd1);
        irq_en = 0; cyc();
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        peek(1, "R5 received byte", 16'h00A5);
        rd_data();

        // R8: software 0 clears the flag
        wr(0, 16'h0003);
        peek(0, "R8 write zero clears", 16'h0003);

        // R6/R7: unread character, then a second one with a mid-transfer write
        inv = 1; wr(1, 16'h003C); wcyc(XFER + 1);
        inv = 0; rises = 0;
        wr(1, 16'h0081); wcyc(5);
        wr(1, 16'h00FF);
        peek(0, "R7 collision flagged", 16'h00D3);
        wcyc(XFER);
        chk("R7 transfer unaltered", {8'h00, cap}, 16'h0081);
        peek(0, "R6 overrun flagged", 16'h0073);
        peek(1, "R6 old byte kept", 16'h00C3);
        irq_en = 1; cyc();
        chk("R10 irq from overrun", {15'd0, irq}, 16'd1);
        wr(0, 16'h0003);
        chk("R8 all flags cleared", {15'd0, irq}, 16'd0);

        // R9: read in the same cycle the next character completes
        wr(1, 16'h005A); wcyc(XFER - 1);
        reg_sel = 1; reg_rd = 1; cyc(); reg_rd = 0; reg_sel = 0;
        peek(0, "R9 no overrun on same-cycle read", 16'h0043);
        peek(1, "R9 new byte stored", 16'h005A);

        // R8: hardware set wins over simultaneous clear
        rd_data(); wr(0, 16'h0003);
        wr(1, 16'h0011); wcyc(XFER - 1);
        reg_sel = 0; reg_wr = 1; reg_wdata = 16'h0003; cyc(); reg_wr = 0;
        peek(0, "R8 set beats clear", 16'h0043);
        rd_data(); wr(0, 16'h0007);

        // R11: mode fault mid-transfer
        wr(1, 16'h00F0); wcyc(5);
        ss_sense_n = 0; cyc(); ss_sense_n = 1;
        peek(0, "R11 fault aborts and drops master", 16'h000D);
        chk("R11 select released", {15'd0, ss_n}, 16'd1);
        chk("R10 fault not in irq", {15'd0, irq}, 16'd0);
        wr(1, 16'h0055); wcyc(3);
        peek(0, "R11 R3 no start without master", 16'h000D);
        wr(0, 16'h0001);
        peek(0, "R8 fault cleared by zero", 16'h0001);

        cyc();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule